// File: doc/BRIEF.md
# Time-Domain Supply Loop Controller

This block is the digital heart of a supply regulator that works in the time domain. Upstream converters turn the reference level and the regulated output level into two pulse trains. The edge timing of each train carries the level it stands for: a lower level gives an earlier edge. The block samples both trains on a fast clock. For every pair of rising edges it records which edge came first and counts the sample ticks between them. It then moves a saturating switch count up or down, and the thermometer-coded enable vector derived from that count drives the bank of power switches.

A leading reference edge means the reference sits below the output, so the count goes down. A leading output edge means the output has sagged, so the count goes up. When a measured gap reaches the programmed boundary, the loop enters a boost mode in which one measurement moves the count by four switches instead of one. The loop returns to single steps as soon as a gap falls back below the boundary.

The pairing logic is a four-state machine. In `PAIR_IDLE` it waits for a rising edge. A reference edge alone moves it to `PAIR_REF_LEAD` and an output edge alone moves it to `PAIR_OUT_LEAD`. Both edges in the same tick complete a tied pair with a gap of zero and go straight to `PAIR_CLEAR`. From either lead state, the missing edge completes the pair and moves to `PAIR_CLEAR`; until then the gap counter advances once per tick. `PAIR_CLEAR` is a one-tick clearing pause that always returns to `PAIR_IDLE`.

Top module: `tdr_loop_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `boost`, `dir_up` and `meas_valid` low and loads `sw_count` with `init_count`, clamped to `N_SW`.
- R2: When the reference rising edge comes first in a pair, the update drives `dir_up` low and lowers `sw_count`.
- R3: When the output rising edge comes first in a pair, the update drives `dir_up` high and raises `sw_count`.
- R4: The gap is the number of clock edges between the edge that samples the first rising edge and the edge that samples the second. `boost` becomes high on an update whose gap is at least the value of `boundary` sampled one clock earlier.
- R5: While `boost` is high, one update moves `sw_count` by four.
- R6: While `boost` is low, one update moves `sw_count` by exactly one. An update whose gap is below the boundary clears `boost`.
- R7: `sw_count` saturates at 0 and at `N_SW`, and never wraps.
- R8: When both rising edges arrive in the same tick, the pair counts as an update with gap 0. `sw_count` and `dir_up` are unchanged by it.
- R9: In the tick after a pair completes, rising edges on either input are ignored. While the machine waits for the second edge, further rising edges on the input that came first are ignored.
- R10: `meas_valid` is high for exactly one cycle per pair. It is high in the cycle after the second clock edge that follows the tick completing the pair, and `sw_count`, `dir_up` and `boost` take their new values in that same cycle. They hold their values between updates.
- R11: Bit i of `sw_enable` is high exactly when i is below `sw_count`.
- R12: The gap counter saturates at 2^GAP_W-1, so a very long gap still compares correctly against a boundary of 2^GAP_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Pulse train derived from the reference level |
| out_pulse | input | 1 | Pulse train derived from the regulated output |
| boundary | input | GAP_W | Gap threshold for boost, in ticks (registered inside) |
| init_count | input | CNT_W | Switch count loaded during reset |
| sw_count | output | CNT_W | Number of enabled power switches |
| sw_enable | output | N_SW | Thermometer-coded switch enables |
| dir_up | output | 1 | Direction of the last non-tied update (1 = up) |
| boost | output | 1 | Fourfold gain mode active |
| meas_valid | output | 1 | One-cycle strobe marking an update |

## Verification
A wrong pairing state shows at the ports as a wrong step or direction on the next `meas_valid`, two cycles after the completing edge. A mis-measured gap shows as `boost` set or cleared on the wrong update, which changes the count by four instead of one. Counter saturation faults appear as wraps to the opposite extreme on the very update that crosses a limit. The reference model tracks edge timestamps rather than states, and every output is compared against it once per cycle, so any divergence is reported in the cycle in which it first becomes visible.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    typedef enum logic [1:0] {
        PAIR_IDLE     = 2'd0,
        PAIR_REF_LEAD = 2'd1,
        PAIR_OUT_LEAD = 2'd2,
        PAIR_CLEAR    = 2'd3
    } pair_state_e;

    localparam int unsigned NORMAL_STEP = 1;
    localparam int unsigned BOOST_STEP  = 4;

endpackage

// File: rtl/tdr_pair_fsm.sv
module tdr_pair_fsm
    import tdr_pkg::*;
#(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             out_pulse,
    output logic             meas_stb,
    output logic [GAP_W-1:0] meas_gap,
    output logic             meas_out_lead,
    output logic             meas_tie
);

    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};
    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

    pair_state_e      state_q, state_nx;
    logic [GAP_W-1:0] gap_q, gap_nx;
    logic             ref_prev_q, out_prev_q;
    logic             ref_rise, out_rise;
    logic             done, done_tie, done_out_lead;
    logic [GAP_W-1:0] done_gap;
    logic [GAP_W-1:0] gap_inc;

    // input history for rising-edge detection
    always_ff @(posedge clk) begin
        ref_prev_q <= ref_pulse;
        out_prev_q <= out_pulse;
    end

    assign ref_rise = ref_pulse & ~ref_prev_q;
    assign out_rise = out_pulse & ~out_prev_q;
    assign gap_inc  = (gap_q == GAP_MAX) ? gap_q : gap_q + GAP_ONE;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PAIR_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_nx;
            gap_q   <= gap_nx;
        end
    end

    // next state and pair completion
    always_comb begin
        state_nx      = state_q;
        gap_nx        = gap_q;
        done          = 1'b0;
        done_tie      = 1'b0;
        done_out_lead = 1'b0;
        done_gap      = gap_q;
        unique case (state_q)
            PAIR_IDLE: begin
                if (ref_rise && out_rise) begin
                    state_nx = PAIR_CLEAR;
                    done     = 1'b1;
                    done_tie = 1'b1;
                    done_gap = '0;
                end else if (ref_rise) begin
                    state_nx = PAIR_REF_LEAD;
                    gap_nx   = GAP_ONE;
                end else if (out_rise) begin
                    state_nx = PAIR_OUT_LEAD;
                    gap_nx   = GAP_ONE;
                end
            end
            PAIR_REF_LEAD: begin
                if (out_rise) begin
                    state_nx = PAIR_CLEAR;
                    done     = 1'b1;
                end else begin
                    gap_nx = gap_inc;
                end
            end
            PAIR_OUT_LEAD: begin
                if (ref_rise) begin
                    state_nx      = PAIR_CLEAR;
                    done          = 1'b1;
                    done_out_lead = 1'b1;
                end else begin
                    gap_nx = gap_inc;
                end
            end
            PAIR_CLEAR: begin
                state_nx = PAIR_IDLE;
            end
            default: state_nx = PAIR_IDLE;
        endcase
    end

    // registered measurement outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            meas_stb      <= 1'b0;
            meas_gap      <= '0;
            meas_out_lead <= 1'b0;
            meas_tie      <= 1'b0;
        end else begin
            meas_stb <= done;
            if (done) begin
                meas_gap      <= done_gap;
                meas_out_lead <= done_out_lead;
                meas_tie      <= done_tie;
            end
        end
    end

endmodule

// File: rtl/tdr_step_counter.sv
module tdr_step_counter
    import tdr_pkg::*;
#(
    parameter int unsigned N_SW  = 64,
    parameter int unsigned CNT_W = 7,
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] init_count,
    input  logic [GAP_W-1:0] boundary_q,
    input  logic             meas_stb,
    input  logic [GAP_W-1:0] meas_gap,
    input  logic             meas_out_lead,
    input  logic             meas_tie,
    output logic [CNT_W-1:0] sw_count,
    output logic             dir_up,
    output logic             boost,
    output logic             upd_stb
);

    localparam int unsigned    SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] TOP   = SUM_W'(N_SW);
    localparam logic [SUM_W-1:0] STEP1 = SUM_W'(NORMAL_STEP);
    localparam logic [SUM_W-1:0] STEP4 = SUM_W'(BOOST_STEP);

    logic             boost_nx;
    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] cur_w, up_sum, dn_val, next_w, init_w;

    assign boost_nx = (meas_gap >= boundary_q);
    assign cur_w    = {1'b0, sw_count};
    assign init_w   = {1'b0, init_count};

    always_comb begin
        if (meas_tie)      step = '0;
        else if (boost_nx) step = STEP4;
        else               step = STEP1;
        up_sum = cur_w + step;
        dn_val = (cur_w < step) ? '0 : cur_w - step;
        if (meas_out_lead) next_w = (up_sum > TOP) ? TOP : up_sum;
        else               next_w = dn_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_count <= (init_w > TOP) ? CNT_W'(N_SW) : init_count;
            dir_up   <= 1'b0;
            boost    <= 1'b0;
            upd_stb  <= 1'b0;
        end else begin
            upd_stb <= meas_stb;
            if (meas_stb) begin
                boost <= boost_nx;
                if (!meas_tie) begin
                    dir_up   <= meas_out_lead;
                    sw_count <= next_w[CNT_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/tdr_thermo.sv
module tdr_thermo #(
    parameter int unsigned N_SW  = 64,
    parameter int unsigned CNT_W = 7
) (
    input  logic [CNT_W-1:0] count,
    output logic [N_SW-1:0]  therm
);

    for (genvar i = 0; i < N_SW; i++) begin : g_bit
        assign therm[i] = (count > CNT_W'(i));
    end

endmodule

// File: rtl/tdr_loop_ctrl.sv
module tdr_loop_ctrl #(
    parameter int unsigned N_SW  = 64,
    parameter int unsigned GAP_W = 8,
    localparam int unsigned CNT_W = $clog2(N_SW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             out_pulse,
    input  logic [GAP_W-1:0] boundary,
    input  logic [CNT_W-1:0] init_count,
    output logic [CNT_W-1:0] sw_count,
    output logic [N_SW-1:0]  sw_enable,
    output logic             dir_up,
    output logic             boost,
    output logic             meas_valid
);

    logic [GAP_W-1:0] boundary_q;
    logic             m_stb, m_out_lead, m_tie;
    logic [GAP_W-1:0] m_gap;

    always_ff @(posedge clk) begin
        boundary_q <= boundary;
    end

    tdr_pair_fsm #(.GAP_W(GAP_W)) u_pair (
        .clk           (clk),
        .rst           (rst),
        .ref_pulse     (ref_pulse),
        .out_pulse     (out_pulse),
        .meas_stb      (m_stb),
        .meas_gap      (m_gap),
        .meas_out_lead (m_out_lead),
        .meas_tie      (m_tie)
    );

    tdr_step_counter #(.N_SW(N_SW), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_count (
        .clk           (clk),
        .rst           (rst),
        .init_count    (init_count),
        .boundary_q    (boundary_q),
        .meas_stb      (m_stb),
        .meas_gap      (m_gap),
        .meas_out_lead (m_out_lead),
        .meas_tie      (m_tie),
        .sw_count      (sw_count),
        .dir_up        (dir_up),
        .boost         (boost),
        .upd_stb       (meas_valid)
    );

    tdr_thermo #(.N_SW(N_SW), .CNT_W(CNT_W)) u_therm (
        .count (sw_count),
        .therm (sw_enable)
    );

endmodule

// File: rtl/tdr_loop_ctrl_checker.sv
module tdr_loop_ctrl_checker #(
    parameter int unsigned N_SW  = 64,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] sw_count,
    input logic [N_SW-1:0]  sw_enable,
    input logic             dir_up,
    input logic             boost,
    input logic             meas_valid
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
        int'(sw_count) <= int'(N_SW));

    a_r11_thermo_pop: assert property (@(posedge clk) disable iff (rst)
        $countones(sw_enable) == int'(sw_count));

    a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
        meas_valid |=> !meas_valid);

    a_r10_hold_between: assert property (@(posedge clk) disable iff (rst)
        (armed && !meas_valid) |-> ($stable(sw_count) && $stable(boost) && $stable(dir_up)));

    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        (armed && meas_valid && !boost) |->
            ((int'(sw_count) - int'($past(sw_count)) <= 1) &&
             (int'($past(sw_count)) - int'(sw_count) <= 1)));

    a_r5_boost_step: assert property (@(posedge clk) disable iff (rst)
        (armed && meas_valid && boost) |->
            ((int'(sw_count) - int'($past(sw_count)) <= 4) &&
             (int'($past(sw_count)) - int'(sw_count) <= 4)));

    a_r2_down_dir: assert property (@(posedge clk) disable iff (rst)
        (armed && meas_valid && !dir_up) |-> (sw_count <= $past(sw_count)));

    a_r3_up_dir: assert property (@(posedge clk) disable iff (rst)
        (armed && meas_valid && dir_up) |-> (sw_count >= $past(sw_count)));

endmodule

bind tdr_loop_ctrl tdr_loop_ctrl_checker #(.N_SW(N_SW), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_count   (sw_count),
    .sw_enable  (sw_enable),
    .dir_up     (dir_up),
    .boost      (boost),
    .meas_valid (meas_valid)
);

// File: tb/tdr_loop_ctrl_bench.sv
module tdr_loop_ctrl_bench;

    localparam int N_SW  = 64;
    localparam int GAP_W = 8;
    localparam int CNT_W = $clog2(N_SW + 1);
    localparam int GAP_SAT = (1 << GAP_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_pulse = 1'b0;
    logic             out_pulse = 1'b0;
    logic [GAP_W-1:0] boundary = GAP_W'(5);
    logic [CNT_W-1:0] init_count = CNT_W'(32);
    logic [CNT_W-1:0] sw_count;
    logic [N_SW-1:0]  sw_enable;
    logic             dir_up, boost, meas_valid;

    always #2 clk = ~clk;

    tdr_loop_ctrl #(.N_SW(N_SW), .GAP_W(GAP_W)) u_tdr_loop_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ref_pulse  (ref_pulse),
        .out_pulse  (out_pulse),
        .boundary   (boundary),
        .init_count (init_count),
        .sw_count   (sw_count),
        .sw_enable  (sw_enable),
        .dir_up     (dir_up),
        .boost      (boost),
        .meas_valid (meas_valid)
    );

    // behavioural reference model based on edge timestamps
    typedef struct {
        int due;
        int gap;
        bit out_lead;
        bit tie;
    } result_t;

    result_t pend[$];
    int  tick = 0;
    int  lead = 0;      // 0 none, 1 reference first, 2 output first
    int  t_first = 0;
    int  blank_until = 0;
    bit  ref_prev_m = 0, out_prev_m = 0;
    int  bnd_prev = 0;
    int  exp_count = 0;
    bit  exp_boost = 0, exp_dir = 0, exp_valid = 0;
    bit  started = 0;

    int  compared = 0;
    int  mismatched = 0;
    string cur_req = "R1";
    bit  finished = 0;
    int  wd = 0;

    function automatic int sat_gap(int g);
        return (g > GAP_SAT) ? GAP_SAT : g;
    endfunction

    always @(posedge clk) begin
        bit rr, orr;
        rr  = ref_pulse && !ref_prev_m;
        orr = out_pulse && !out_prev_m;
        started = 1;
        if (rst) begin
            exp_count = (int'(init_count) > N_SW) ? N_SW : int'(init_count);
            exp_boost = 0;
            exp_dir   = 0;
            exp_valid = 0;
            lead = 0;
            blank_until = 0;
            pend.delete();
        end else begin
            exp_valid = 0;
            if (pend.size() > 0 && pend[0].due == tick) begin
                result_t r;
                int step;
                r = pend.pop_front();
                exp_valid = 1;
                exp_boost = (r.gap >= bnd_prev);
                step = r.tie ? 0 : (exp_boost ? 4 : 1);
                if (!r.tie) begin
                    exp_dir = r.out_lead;
                    if (r.out_lead) exp_count = (exp_count + step > N_SW) ? N_SW : exp_count + step;
                    else            exp_count = (exp_count < step) ? 0 : exp_count - step;
                end
            end
            if (tick >= blank_until) begin
                if (lead == 0) begin
                    if (rr && orr) begin
                        pend.push_back('{tick + 1, 0, 1'b0, 1'b1});
                        blank_until = tick + 2;
                    end else if (rr) begin
                        lead = 1; t_first = tick;
                    end else if (orr) begin
                        lead = 2; t_first = tick;
                    end
                end else if (lead == 1 && orr) begin
                    pend.push_back('{tick + 1, sat_gap(tick - t_first), 1'b0, 1'b0});
                    lead = 0; blank_until = tick + 2;
                end else if (lead == 2 && rr) begin
                    pend.push_back('{tick + 1, sat_gap(tick - t_first), 1'b1, 1'b0});
                    lead = 0; blank_until = tick + 2;
                end
            end
        end
        ref_prev_m = ref_pulse;
        out_prev_m = out_pulse;
        bnd_prev   = int'(boundary);
        tick++;
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            logic [N_SW-1:0] exp_en;
            for (int i = 0; i < N_SW; i++) exp_en[i] = (i < exp_count);
            compared++;
            if (int'(sw_count) != exp_count || sw_enable != exp_en ||
                dir_up != exp_dir || boost != exp_boost || meas_valid != exp_valid) begin
                mismatched++;
                $display("FAIL %s t=%0d: count=%0d en=%h dir=%0b boost=%0b valid=%0b | expected count=%0d en=%h dir=%0b boost=%0b valid=%0b",
                         cur_req, tick, sw_count, sw_enable, dir_up, boost, meas_valid,
                         exp_count, exp_en, exp_dir, exp_boost, exp_valid);
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // first_is_out: 1 = output edge leads; gap in ticks (0 = simultaneous)
    task automatic pair(bit first_is_out, int gap);
        @(negedge clk);
        if (gap == 0) begin
            ref_pulse = 1; out_pulse = 1;
            @(negedge clk);
            ref_pulse = 0; out_pulse = 0;
        end else begin
            if (first_is_out) out_pulse = 1; else ref_pulse = 1;
            @(negedge clk);
            out_pulse = 0; ref_pulse = 0;
            repeat (gap - 1) @(negedge clk);
            if (first_is_out) ref_pulse = 1; else out_pulse = 1;
            @(negedge clk);
            out_pulse = 0; ref_pulse = 0;
        end
        idle(4);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst = 0;
        idle(3);

        cur_req = "R3";  pair(1, 2);           // up by one
        cur_req = "R2";  pair(0, 3);           // down by one
        cur_req = "R4";  pair(1, 7);           // boost on
        cur_req = "R5";  pair(1, 5);           // gap equals boundary, still boost
        cur_req = "R6";  pair(0, 4);           // gap below boundary, back to single step
        cur_req = "R6";  pair(1, 1);
        cur_req = "R8";  pair(0, 0);           // tied pair
        cur_req = "R8";  pair(1, 0);

        // R9: edges inside the clearing tick are ignored
        cur_req = "R9";
        @(negedge clk); out_pulse = 1;
        @(negedge clk); out_pulse = 0;
        @(negedge clk); ref_pulse = 1;          // completes pair
        @(negedge clk); ref_pulse = 0; out_pulse = 1;   // clearing tick: ignored
        @(negedge clk); out_pulse = 0;
        idle(6);
        // R9: repeated edge on the leading input is ignored
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        @(negedge clk); out_pulse = 1;
        @(negedge clk); out_pulse = 0;
        idle(6);

        // R7: saturate at zero with boosted steps
        cur_req = "R7";
        for (int k = 0; k < 12; k++) pair(0, 9);
        // R7: saturate at the top
        for (int k = 0; k < 20; k++) pair(1, 9);
        pair(1, 2);

        // R10: back-to-back pairs, minimal spacing
        cur_req = "R10";
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0; out_pulse = 1;
        @(negedge clk); out_pulse = 0;
        @(negedge clk); ref_pulse = 1; out_pulse = 1;
        @(negedge clk); ref_pulse = 0; out_pulse = 0;
        idle(6);

        // R12: long gap against maximum boundary
        cur_req = "R12";
        boundary = GAP_W'(GAP_SAT);
        idle(2);
        pair(0, 300);
        pair(0, 100);

        // R4: zero boundary boosts every pair
        cur_req = "R4";
        boundary = '0;
        idle(2);
        pair(0, 1);
        pair(1, 0);

        // R11 / R1: reset with over-range init value, then move
        cur_req = "R11";
        init_count = CNT_W'(100);
        @(negedge clk); rst = 1;
        idle(2);
        rst = 0;
        boundary = GAP_W'(6);
        idle(2);
        pair(0, 2);
        pair(0, 6);
        init_count = CNT_W'(3);
        @(negedge clk); rst = 1;
        idle(2);
        rst = 0;
        idle(2);
        pair(0, 8);
        pair(1, 3);
        idle(5);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule